// File: doc/BRIEF.md
# TDM Multichannel Audio Serializer

This block turns sixteen 16-bit audio channels into one time-division-multiplexed serial stream with its own bit clock and frame sync. A frame has eight 32-bit slots, 256 bit periods in all. Each slot carries two channels: the even channel in the upper half and the odd channel in the lower half. Bits go out most significant first. The bit clock is made inside the block and toggles once for every pulse on `mclk_en`, a one-cycle strobe at the master clock rate. The bit clock therefore runs at half the master clock, and the master clock runs at 512 times the frame rate.

A producer hands over a complete 16-channel sample set through a valid/ready handshake into a single holding register. A per-channel presence mask comes with each set, and absent channels go out as zero. At the start of every frame the holding register is copied into the frame shift register. If no set is waiting at that moment, the whole frame is sent as zero and a one-cycle underrun pulse is raised. The frame-start cycle frees the holding register, and a new set may be accepted in that same cycle.

Top module: `tdm_serializer`

## Requirements
- R1: Frame sync is high at exactly one rising bit-clock edge per frame, and exactly 256 rising edges separate two consecutive syncs.
- R2: The 256 bits following a sync are slot 0 to slot 7, each sent from bit 31 down to bit 0. Slot k carries channel 2k in bits 31:16 and channel 2k+1 in bits 15:0. Channel c is taken from `smp_data[16c+15:16c]`.
- R3: Frame sync lasts one bit period and is driven during the last bit of the previous frame, one bit period before bit 31 of slot 0.
- R4: The bit clock toggles on each `mclk_en` pulse and at no other time. Serial data and frame sync change only in the clock cycle in which the bit clock falls.
- R5: A channel whose bit in `smp_present` (bit c for channel c) is 0 is sent as sixteen zero bits.
- R6: `smp_ready` is high when the holding register is empty, and also in the frame-start cycle. A set held back and not yet used by a frame keeps `smp_ready` low while `mclk_en` is low. Accepted sets are sent in acceptance order, one per frame.
- R7: If no set is held at a frame start, all 256 bits of that frame are zero. `underrun` is then high for exactly one cycle, the cycle after that frame's first falling bit-clock edge.
- R8: While `rst_n` is low, the bit clock, data, frame sync and underrun outputs are low and `smp_ready` is high. After release, the first falling bit-clock edge raises frame sync, and the second one starts slot 0 bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mclk_en | input | 1 | One-cycle strobe at master clock rate; paces the bit clock |
| smp_valid | input | 1 | A sample set is offered |
| smp_data | input | 256 | Sixteen 16-bit channels, channel c at bits 16c+15:16c |
| smp_present | input | 16 | Channel c carries a sample when bit c is 1 |
| smp_ready | output | 1 | Holding register can take a set this cycle |
| tdm_bclk | output | 1 | Bit clock |
| tdm_fsync | output | 1 | Frame sync, one bit period wide |
| tdm_sdata | output | 1 | Serial data, MSB first, changes at bit-clock fall |
| underrun | output | 1 | One-cycle pulse when a frame starts with no set held |

## Verification
Two functions can fall in the same clock cycle. Frame start copies and frees the holding register, and the handshake may accept a new set in that cycle. A producer that keeps `smp_valid` high after each acceptance makes this coincidence happen on almost every frame. A producer that arrives late, after a starved gap, can land on a frame start while the register is empty, so that frame underruns and the new set goes into the next frame. The bench decodes every frame from the serial line at rising bit-clock edges. It matches each decoded frame against the next set in its own queue of accepted sets, or against all-zero when an underrun pulse was seen after that frame's sync. A lost, doubled or misordered set shows up as a content mismatch.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // Phase of the generated bit clock
  typedef enum logic {
    BCLK_LOW  = 1'b0,
    BCLK_HIGH = 1'b1
  } bclk_phase_e;

  localparam int unsigned DEF_SLOTS       = 8;
  localparam int unsigned DEF_CH_PER_SLOT = 2;
  localparam int unsigned DEF_CH_W        = 16;
endpackage

// File: rtl/tdm_bclk_gen.sv
module tdm_bclk_gen
  import tdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_en,
  output logic bclk,
  output logic fall_stb
);

  bclk_phase_e phase_q;
  bclk_phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (mclk_en) begin
      phase_d = (phase_q == BCLK_HIGH) ? BCLK_LOW : BCLK_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= BCLK_LOW;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign bclk     = (phase_q == BCLK_HIGH);
  // this cycle's enable takes the clock from high to low
  assign fall_stb = mclk_en && (phase_q == BCLK_HIGH);

endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_stb,
  output logic fsync,
  output logic frame_start
);

  localparam int unsigned PW = $clog2(FRAME_BITS);
  localparam logic [PW-1:0] LAST_POS  = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] RESET_POS = PW'(FRAME_BITS - 2);

  logic [PW-1:0] pos_q, pos_d, pos_nx;
  logic          fsync_q, fsync_d;

  assign pos_nx = (pos_q == LAST_POS) ? '0 : pos_q + PW'(1);

  always_comb begin
    pos_d   = pos_q;
    fsync_d = fsync_q;
    if (fall_stb) begin
      pos_d   = pos_nx;
      // sync rides on the final bit of the outgoing frame
      fsync_d = (pos_nx == LAST_POS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= RESET_POS;
      fsync_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      fsync_q <= fsync_d;
    end
  end

  assign fsync       = fsync_q;
  assign frame_start = fall_stb && (pos_q == LAST_POS);

endmodule

// File: rtl/tdm_sample_hold.sv
module tdm_sample_hold #(
  parameter int unsigned SLOTS       = 8,
  parameter int unsigned CH_PER_SLOT = 2,
  parameter int unsigned CH_W        = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic [SLOTS*CH_PER_SLOT*CH_W-1:0]   in_data,
  input  logic [SLOTS*CH_PER_SLOT-1:0]        in_present,
  input  logic                                take,
  output logic                                in_ready,
  output logic                                full,
  output logic [SLOTS*CH_PER_SLOT*CH_W-1:0]   frame_vec
);

  localparam int unsigned SLOT_W     = CH_PER_SLOT * CH_W;
  localparam int unsigned CH         = SLOTS * CH_PER_SLOT;
  localparam int unsigned FRAME_BITS = SLOTS * SLOT_W;

  logic [FRAME_BITS-1:0] packed_vec;
  logic [FRAME_BITS-1:0] hold_q;
  logic                  full_q, full_d;
  logic                  accept;

  // frame order: slot 0 first, lower channel number in the upper half
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < CH_PER_SLOT; p++) begin : g_half
      localparam int unsigned CIDX = s * CH_PER_SLOT + p;
      localparam int unsigned TOP  = FRAME_BITS - 1 - s * SLOT_W - p * CH_W;
      assign packed_vec[TOP -: CH_W] =
        in_present[CIDX] ? in_data[CIDX*CH_W +: CH_W] : '0;
    end
  end

  assign in_ready = !full_q || take;
  assign accept   = in_valid && in_ready;

  always_comb begin
    full_d = full_q;
    if (accept) begin
      full_d = 1'b1;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  // payload needs no reset: it is read only while full_q is set
  always_ff @(posedge clk) begin
    if (accept) begin
      hold_q <= packed_vec;
    end
  end

  assign full      = full_q;
  assign frame_vec = hold_q;

  logic unused_ok;
  assign unused_ok = ^CH;

endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fall_stb,
  input  logic                  load,
  input  logic                  load_ok,
  input  logic [FRAME_BITS-1:0] load_vec,
  output logic                  sdata,
  output logic                  underrun
);

  logic [FRAME_BITS-1:0] sh_q, sh_d, src;
  logic                  sd_q, sd_d;
  logic                  ur_q, ur_d;

  assign src = load_ok ? load_vec : '0;

  always_comb begin
    sh_d = sh_q;
    sd_d = sd_q;
    ur_d = 1'b0;
    if (fall_stb) begin
      if (load) begin
        sd_d = src[FRAME_BITS-1];
        sh_d = {src[FRAME_BITS-2:0], 1'b0};
        ur_d = !load_ok;
      end else begin
        sd_d = sh_q[FRAME_BITS-1];
        sh_d = {sh_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sd_q <= 1'b0;
      ur_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      sd_q <= sd_d;
      ur_q <= ur_d;
    end
  end

  assign sdata    = sd_q;
  assign underrun = ur_q;

endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer #(
  parameter int unsigned SLOTS       = 8,
  parameter int unsigned CH_PER_SLOT = 2,
  parameter int unsigned CH_W        = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              mclk_en,
  input  logic                              smp_valid,
  input  logic [SLOTS*CH_PER_SLOT*CH_W-1:0] smp_data,
  input  logic [SLOTS*CH_PER_SLOT-1:0]      smp_present,
  output logic                              smp_ready,
  output logic                              tdm_bclk,
  output logic                              tdm_fsync,
  output logic                              tdm_sdata,
  output logic                              underrun
);

  localparam int unsigned SLOT_W     = CH_PER_SLOT * CH_W;
  localparam int unsigned FRAME_BITS = SLOTS * SLOT_W;

  logic                  fall_stb;
  logic                  frame_start;
  logic                  hold_full;
  logic [FRAME_BITS-1:0] hold_vec;

  tdm_bclk_gen u_bclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mclk_en  (mclk_en),
    .bclk     (tdm_bclk),
    .fall_stb (fall_stb)
  );

  tdm_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_stb    (fall_stb),
    .fsync       (tdm_fsync),
    .frame_start (frame_start)
  );

  tdm_sample_hold #(
    .SLOTS       (SLOTS),
    .CH_PER_SLOT (CH_PER_SLOT),
    .CH_W        (CH_W)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (smp_valid),
    .in_data    (smp_data),
    .in_present (smp_present),
    .take       (frame_start),
    .in_ready   (smp_ready),
    .full       (hold_full),
    .frame_vec  (hold_vec)
  );

  tdm_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_stb (fall_stb),
    .load     (frame_start),
    .load_ok  (hold_full),
    .load_vec (hold_vec),
    .sdata    (tdm_sdata),
    .underrun (underrun)
  );

endmodule

// File: rtl/tdm_serializer_chk.sv
module tdm_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_ready,
  input logic tdm_bclk,
  input logic tdm_fsync,
  input logic tdm_sdata,
  input logic underrun
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!tdm_bclk && !tdm_fsync && !tdm_sdata && !underrun && smp_ready); // R8
    end
  end

  AST_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((tdm_fsync != $past(tdm_fsync)) || (tdm_sdata != $past(tdm_sdata))) |-> ($past(tdm_bclk) && !tdm_bclk)); // R4

  AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tdm_bclk) && !tdm_bclk && $past(tdm_fsync)) |-> !tdm_fsync); // R3

  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun); // R7

  AST_UNDERRUN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> ($past(tdm_fsync) && !tdm_fsync)); // R7

endmodule

bind tdm_serializer tdm_serializer_chk u_chk (.*);

// File: tb/tdm_serializer_bench.sv
module tdm_serializer_bench;

  localparam int CH  = 16;
  localparam int CHW = 16;
  localparam int FB  = 256;

  logic          clk;
  logic          rst_n;
  logic          mclk_en;
  logic          smp_valid;
  logic [FB-1:0] smp_data;
  logic [CH-1:0] smp_present;
  logic          smp_ready;
  logic          tdm_bclk, tdm_fsync, tdm_sdata, underrun;

  tdm_serializer u_tdm_serializer (
    .clk         (clk),
    .rst_n       (rst_n),
    .mclk_en     (mclk_en),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .smp_present (smp_present),
    .smp_ready   (smp_ready),
    .tdm_bclk    (tdm_bclk),
    .tdm_fsync   (tdm_fsync),
    .tdm_sdata   (tdm_sdata),
    .underrun    (underrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int frames   = 0;
  int ur_count = 0;
  int r4_err   = 0;
  int r3_err   = 0;
  int nbits    = 0;
  bit hold_en  = 1'b1;
  bit in_frame = 1'b0;
  bit ur_seen  = 1'b0;
  bit after_rst = 1'b1;
  logic bclk_p = 1'b0, fsync_p = 1'b0, sdata_p = 1'b0, rst_p = 1'b0, fs_rise_p = 1'b0;
  logic en_old;
  logic [FB-1:0] fr, ex;
  logic [FB-1:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [FB-1:0] act, input logic [FB-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic [FB-1:0] pack_exp(input logic [FB-1:0] d, input logic [CH-1:0] pr);
    logic [FB-1:0] f;
    f = '0;
    for (int c = 0; c < CH; c++) begin
      if (pr[c]) f[FB-1-CHW*c -: CHW] = d[CHW*c +: CHW];
    end
    return f;
  endfunction

  function automatic logic [FB-1:0] rand_data();
    logic [FB-1:0] r;
    for (int i = 0; i < FB/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      finish_run();
    end
  end

  // monitor, decoder and enable driver in one process
  always @(negedge clk) begin
    en_old = mclk_en;
    if (rst_n && rst_p) begin
      if (en_old != (tdm_bclk != bclk_p)) r4_err++;
      if (((tdm_fsync != fsync_p) || (tdm_sdata != sdata_p)) && !(bclk_p && !tdm_bclk)) r4_err++;
      if (bclk_p && !tdm_bclk && after_rst) begin
        chk(tdm_fsync && !tdm_sdata, "R8 first fall after reset raises sync", {tdm_fsync, tdm_sdata}, 2'b10);
        after_rst = 1'b0;
      end
      if (underrun) begin
        ur_seen = 1'b1;
        ur_count++;
      end
      if (!bclk_p && tdm_bclk) begin
        if (in_frame) begin
          fr = {fr[FB-2:0], tdm_sdata};
          nbits++;
        end
        if (tdm_fsync) begin
          if (fs_rise_p) r3_err++;
          if (in_frame) begin
            chk(nbits == 256, "R1 bits between syncs", nbits, 256);
            if (ur_seen) begin
              chk(fr == '0, "R7 underrun frame zero", fr, '0);
            end else if (exp_q.size() == 0) begin
              chk(1'b0, "R6 frame without accepted set", fr, '0);
            end else begin
              ex = exp_q.pop_front();
              chk(fr == ex, "R2 R5 R6 slot packing and order", fr, ex);
            end
            chk(r4_err == 0, "R4 edge discipline errors", r4_err, 0);
            chk(r3_err == 0, "R3 sync width errors", r3_err, 0);
            frames++;
          end
          in_frame = 1'b1;
          nbits    = 0;
          ur_seen  = 1'b0;
        end
        fs_rise_p = tdm_fsync;
      end
    end else if (!rst_n) begin
      in_frame  = 1'b0;
      ur_seen   = 1'b0;
      after_rst = 1'b1;
      fs_rise_p = 1'b0;
      exp_q.delete();
    end
    bclk_p  = tdm_bclk;
    fsync_p = tdm_fsync;
    sdata_p = tdm_sdata;
    rst_p   = rst_n;
    mclk_en = hold_en ? 1'b0 : 1'($urandom % 2);
  end

  task automatic send(input logic [FB-1:0] d, input logic [CH-1:0] pr);
    @(negedge clk);
    smp_valid   = 1'b1;
    smp_data    = d;
    smp_present = pr;
    forever begin
      #1;
      if (smp_ready) begin
        exp_q.push_back(pack_exp(d, pr));
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frames + n;
    while (frames < target) @(negedge clk);
  endtask

  initial begin
    logic [FB-1:0] alt;
    void'($urandom(32'h5eed_1234));
    rst_n       = 1'b0;
    mclk_en     = 1'b0;
    smp_valid   = 1'b0;
    smp_data    = '0;
    smp_present = '0;
    repeat (5) @(negedge clk);
    #1;
    chk(!tdm_bclk && !tdm_fsync && !tdm_sdata && !underrun, "R8 outputs low in reset",
        {tdm_bclk, tdm_fsync, tdm_sdata, underrun}, '0);
    chk(smp_ready, "R8 ready high in reset", smp_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    // directed: full-scale set, then check ready held low with the enable off
    send({FB{1'b1}}, {CH{1'b1}});
    @(negedge clk);
    #1;
    chk(!smp_ready, "R6 ready low while set held", smp_ready, 0);
    hold_en = 1'b0;
    send(rand_data(), '0);                    // R5 no channel present
    send(rand_data(), 16'h5555);              // R5 odd channels absent
    for (int c = 0; c < CH; c++) alt[CHW*c +: CHW] = (c % 2 == 0) ? 16'h8000 : 16'h0001;
    send(alt, {CH{1'b1}});                    // R2 half boundaries
    for (int i = 0; i < 12; i++) send(rand_data(), 16'($urandom));
    // starve: held set drains, then frames underrun (R7)
    wait_frames(4);
    chk(ur_count >= 2, "R7 underrun pulses seen", ur_count, 2);
    // sets with random gaps, arrivals fall on frame starts at random
    for (int i = 0; i < 10; i++) begin
      repeat ($urandom % 1500) @(negedge clk);
      send(rand_data(), 16'($urandom) | 16'h0101);
    end
    wait (exp_q.size() == 0);
    // reset in mid-frame
    repeat (300 + $urandom % 300) @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(!tdm_bclk && !tdm_fsync && !tdm_sdata && !underrun && smp_ready, "R8 mid-run reset quiet",
        {tdm_bclk, tdm_fsync, tdm_sdata, underrun, smp_ready}, 5'b00001);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) send(rand_data(), 16'($urandom));
    wait (exp_q.size() == 0);
    chk(frames >= 30, "R1 frames decoded", frames, 30);
    finish_run();
  end

endmodule